// File: doc/BRIEF.md
# Expansion Bus 32-bit Target Slice

This block is the target side of a 32-bit expansion bus card. Each bus cycle has two parts. First comes a one-clock start phase, in which the master drives the address and the memory/IO select. Then comes a command phase, in which data moves. During the start phase the block compares the address with two windows: a memory window and an I/O window. On a match it claims the cycle and signals that it accepts 32-bit transfers.

While an address-enable line marks the address as owned by a DMA controller, I/O decode is suppressed. Memory decode is not affected by that line.

Once it has claimed a cycle, the block captures the direction, the register index and the byte enables at the rising edge that ends the start phase. It then holds the ready line low for a programmable number of falling-edge samples. The block serves a 16-word register file: reads are driven for the whole command phase, and writes are committed with byte masking on the edge that ends the cycle. All of its bus drivers are released one clock after the command strobe goes inactive.

Top module: `xbus_target`

## Requirements
- R1: After a synchronous active-low reset, `sz32_n` is 1, `wait_req` is 0, `rd_oe` is 0, and every register reads as zero.
- R2: A start edge (`strt_n` low at a rising edge) with `mem_sel`=1 and `bus_addr[31:6]` equal to the memory base claims the cycle. From that edge until release, `sz32_n` is 0.
- R3: A start edge with `mem_sel`=0, `dma_aen`=0 and `bus_addr[31:6]` equal to the I/O base claims the cycle. With `dma_aen`=1 the same access is not claimed: `sz32_n` stays 1 and nothing is written.
- R4: Claiming the memory window does not depend on `dma_aen`.
- R5: An address outside the selected window, or a window address presented with the other space selected, is not claimed: no size indication, no wait, no data drive, no write.
- R6: With `wait_cfg`=N latched at the start edge, a claimed cycle shows `wait_req`=1 at exactly N falling edges after the start edge, and 0 from the next falling edge on.
- R7: A claimed write updates register `bus_addr[5:2]` on the rising edge that ends the cycle. Byte k (`wr_data[8k+7:8k]`) is written only when `be_n[k]`=0.
- R8: During a claimed read, `rd_oe`=1 and `rd_data` equals the addressed register at every falling edge of the command phase. `rd_oe` is 0 during a start phase.
- R9: The address, space, direction, byte enables and wait count are used only at the start edge. Changing them during the command phase has no effect.
- R10: At the first rising edge that samples both `cmd_n` and `strt_n` high, `sz32_n` returns to 1 and `wait_req` and `rd_oe` return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strt_n | input | 1 | Start-phase strobe, active low |
| cmd_n | input | 1 | Command-phase strobe, active low |
| mem_sel | input | 1 | 1 = memory space, 0 = I/O space |
| dma_aen | input | 1 | Address owned by DMA; blocks I/O decode |
| bus_addr | input | 32 | Byte address |
| wr | input | 1 | 1 = write, 0 = read |
| be_n | input | 4 | Byte enables, active low |
| wr_data | input | 32 | Write data from master |
| wait_cfg | input | 3 | Wait states to insert (0..7) |
| sz32_n | output | 1 | 32-bit size indication, active low |
| wait_req | output | 1 | 1 = pull ready low (wait) |
| rd_oe | output | 1 | Read data drive enable |
| rd_data | output | 32 | Read data, zero when not driven |

## Verification
Every output is a register or a function of registers, so the bench drives inputs 1 ns after a rising edge and samples outputs on the falling edge. This mirrors how the master samples ready.

The size indication and the first wait/ready decision are due at the first falling edge after the start edge. Ready is due N falling edges later. Release is due at the falling edge that follows the first rising edge with both strobes inactive.

A write lands on the cycle's closing edge, so the bench confirms it with a later read cycle that compares against a bench-side byte-masked model. Each bus-cycle task counts the wait samples and compares the count with N, or with zero for an unclaimed cycle.

// File: rtl/xbus_pkg.sv
// Shared definitions for the expansion bus target slice.
// Assumes byte lanes of 8 bits.
package xbus_pkg;
    localparam int LANE_W = 8;

    // Address space selected by the master during the start phase.
    typedef enum logic {
        SPACE_IO  = 1'b0,
        SPACE_MEM = 1'b1
    } space_e;
endpackage

// File: rtl/xbus_decode.sv
// Window decoder: compares the start-phase address with a memory window and
// an I/O window of equal size. I/O decode is blocked while the DMA
// address-enable line is high. Purely combinational; the caller samples it
// on the start edge only.
module xbus_decode #(
    parameter int               ADDR_W   = 32,
    parameter int               WIN_LSB  = 6,
    parameter logic [ADDR_W-1:0] MEM_BASE = 32'h000D_0000,
    parameter logic [ADDR_W-1:0] IO_BASE  = 32'h0000_0C40
) (
    input  logic              mem_sel,
    input  logic              dma_aen,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    import xbus_pkg::*;

    localparam int TAG_W = ADDR_W - WIN_LSB;

    logic [TAG_W-1:0] tag;
    logic             mem_match;
    logic             io_match;
    space_e           space;

    // Split out the window tag and the space of the access.
    always_comb begin
        tag   = addr[ADDR_W-1:WIN_LSB];
        space = space_e'(mem_sel);
    end

    // Compare against each window; DMA ownership blocks only the I/O window.
    always_comb begin
        mem_match = (space == SPACE_MEM) && (tag == MEM_BASE[ADDR_W-1:WIN_LSB]);
        io_match  = (space == SPACE_IO) && !dma_aen
                    && (tag == IO_BASE[ADDR_W-1:WIN_LSB]);
        hit       = mem_match || io_match;
    end
endmodule

// File: rtl/xbus_wait.sv
// Wait-state timer. It is loaded with the configured count at the start
// edge, then counts down once per rising edge of the command phase.
// 'done' is high when no more waits are owed. Assumes the load and the run
// conditions come from the bus strobes.
module xbus_wait #(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              run,
    input  logic [WAIT_W-1:0] cfg,
    output logic              done
);
    logic [WAIT_W-1:0] cnt_q;

    // Load on the start edge, count down during the command phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= cfg;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // No waits are owed once the counter reaches zero.
    always_comb done = (cnt_q == '0);

    // R6
    wait_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(cfg)));

    // R6
    wait_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && run && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/xbus_regs.sv
// Register file with byte-lane write masking and an asynchronous read port.
// Each lane of each word is its own small register. Assumes DATA_W is a
// multiple of 8.
module xbus_regs #(
    parameter int REGS   = 16,
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [$clog2(REGS)-1:0]   widx,
    input  logic [DATA_W/8-1:0]       be,
    input  logic [DATA_W-1:0]         wdata,
    input  logic [$clog2(REGS)-1:0]   ridx,
    output logic [DATA_W-1:0]         rdata
);
    localparam int LANES = DATA_W / 8;
    localparam int IDX_W = $clog2(REGS);

    logic [REGS-1:0][DATA_W-1:0] mem;

    for (genvar w = 0; w < REGS; w++) begin : g_word
        for (genvar b = 0; b < LANES; b++) begin : g_lane
            logic [7:0] lane_q;

            // Write this byte lane when its word is addressed and its enable is set.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lane_q <= '0;
                end else if (we && widx == IDX_W'(w) && be[b]) begin
                    lane_q <= wdata[8*b +: 8];
                end
            end

            assign mem[w][8*b +: 8] = lane_q;
        end
    end

    // Read port: selects the addressed word.
    always_comb rdata = mem[ridx];
endmodule

// File: rtl/xbus_target.sv
// Target-side logic of a 32-bit expansion bus card.
// Start phase: the window is decoded, and the selection, direction, register
// index, byte enables and wait count are captured on the start edge.
// Command phase: ready is held low (wait_req) for the programmed number of
// falling-edge samples, read data is driven throughout, and a write is
// committed on the edge that ends the cycle.
// Release: all drivers are freed one clock after the command strobe is seen
// inactive.
// Assumes inputs change away from the rising edge and that the master ends a
// cycle on the rising edge after it samples ready.
module xbus_target #(
    parameter int                ADDR_W   = 32,
    parameter int                DATA_W   = 32,
    parameter int                REGS     = 16,
    parameter int                WAIT_W   = 3,
    parameter logic [ADDR_W-1:0] MEM_BASE = 32'h000D_0000,
    parameter logic [ADDR_W-1:0] IO_BASE  = 32'h0000_0C40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strt_n,
    input  logic              cmd_n,
    input  logic              mem_sel,
    input  logic              dma_aen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wr,
    input  logic [DATA_W/8-1:0] be_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [WAIT_W-1:0] wait_cfg,
    output logic              sz32_n,
    output logic              wait_req,
    output logic              rd_oe,
    output logic [DATA_W-1:0] rd_data
);
    localparam int LANES   = DATA_W / 8;
    localparam int IDX_W   = $clog2(REGS);
    localparam int WIN_LSB = IDX_W + $clog2(LANES);

    logic             hit;
    logic             sel_q;
    logic             wr_q;
    logic [IDX_W-1:0] idx_q;
    logic [LANES-1:0] be_q;
    logic             wait_done;
    logic             reg_we;
    logic [DATA_W-1:0] reg_rdata;

    xbus_decode #(
        .ADDR_W  (ADDR_W),
        .WIN_LSB (WIN_LSB),
        .MEM_BASE(MEM_BASE),
        .IO_BASE (IO_BASE)
    ) u_decode (
        .mem_sel(mem_sel),
        .dma_aen(dma_aen),
        .addr   (bus_addr),
        .hit    (hit)
    );

    // Capture the decode and the access attributes on the start edge; clear
    // the selection once the command strobe is inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            wr_q  <= 1'b0;
            idx_q <= '0;
            be_q  <= '0;
        end else if (!strt_n) begin
            sel_q <= hit;
            wr_q  <= wr;
            idx_q <= bus_addr[WIN_LSB-1:WIN_LSB-IDX_W];
            be_q  <= ~be_n;
        end else if (cmd_n) begin
            sel_q <= 1'b0;
        end
    end

    xbus_wait #(
        .WAIT_W(WAIT_W)
    ) u_wait (
        .clk  (clk),
        .rst_n(rst_n),
        .load (!strt_n),
        .run  (!cmd_n),
        .cfg  (wait_cfg),
        .done (wait_done)
    );

    // Commit a write on the edge that ends a claimed command phase.
    always_comb reg_we = sel_q && wr_q && !cmd_n && strt_n && wait_done;

    xbus_regs #(
        .REGS  (REGS),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (reg_we),
        .widx (idx_q),
        .be   (be_q),
        .wdata(wr_data),
        .ridx (idx_q),
        .rdata(reg_rdata)
    );

    // Bus-facing outputs, all derived from registered state.
    always_comb begin
        sz32_n   = !sel_q;
        wait_req = sel_q && !wait_done;
        rd_oe    = sel_q && !wr_q;
        rd_data  = rd_oe ? reg_rdata : '0;
    end

    // R10
    release_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_n && strt_n) |=> (sz32_n && !wait_req && !rd_oe));

    // R3
    io_aen_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strt_n && dma_aen && !mem_sel) |=> sz32_n);

    // R9
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strt_n && !cmd_n) |=> ($stable(idx_q) && $stable(wr_q) && $stable(be_q)));

    // R5
    miss_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strt_n && !hit) |=> (sz32_n && !wait_req && !rd_oe));
endmodule

// File: tb/sim_xbus_target.sv
// Directed bench for xbus_target: one task per scenario, each checking itself.
module sim_xbus_target;
    localparam logic [31:0] MEM_BASE = 32'h000D_0000;
    localparam logic [31:0] IO_BASE  = 32'h0000_0C40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strt_n = 1'b1;
    logic        cmd_n = 1'b1;
    logic        mem_sel = 1'b0;
    logic        dma_aen = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        wr = 1'b0;
    logic [3:0]  be_n = 4'hF;
    logic [31:0] wr_data = '0;
    logic [2:0]  wait_cfg = '0;
    logic        sz32_n;
    logic        wait_req;
    logic        rd_oe;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [16];

    always #2.5 clk = ~clk;

    xbus_target u0 (
        .clk(clk), .rst_n(rst_n), .strt_n(strt_n), .cmd_n(cmd_n),
        .mem_sel(mem_sel), .dma_aen(dma_aen), .bus_addr(bus_addr), .wr(wr),
        .be_n(be_n), .wr_data(wr_data), .wait_cfg(wait_cfg),
        .sz32_n(sz32_n), .wait_req(wait_req), .rd_oe(rd_oe), .rd_data(rd_data)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One complete bus cycle with checks on size, waits, read data and release.
    task automatic bus_cycle(input logic m, input logic [31:0] a, input logic w,
                             input logic [3:0] ben, input logic [31:0] d,
                             input logic ae, input logic [2:0] nw,
                             input logic exp_hit, input logic scramble,
                             input string req);
        int waits = 0;
        int idx = int'(a[5:2]);
        @(posedge clk); #1;
        strt_n = 1'b0; cmd_n = 1'b1; mem_sel = m; bus_addr = a; wr = w;
        be_n = ben; wr_data = d; dma_aen = ae; wait_cfg = nw;
        @(negedge clk);
        chk(rd_oe == 1'b0, "R8", "rd_oe in start phase", 32'(rd_oe), 0);
        @(posedge clk); #1;
        strt_n = 1'b1; cmd_n = 1'b0;
        if (scramble) begin
            bus_addr = a ^ 32'h0000_0014; mem_sel = ~m; wr = ~w;
            be_n = ~ben; wait_cfg = ~nw;
        end
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk(sz32_n == !exp_hit, req, "sz32_n in command", 32'(sz32_n), 32'(!exp_hit));
            if (exp_hit && !w)
                chk(rd_oe && rd_data == model[idx], "R8", "read data",
                    rd_data, model[idx]);
            else
                chk(rd_oe == 1'b0, req, "rd_oe", 32'(rd_oe), 0);
            if (!wait_req) break;
            waits++;
            @(posedge clk);
        end
        chk(waits == (exp_hit ? int'(nw) : 0), "R6", "wait samples",
            32'(waits), exp_hit ? 32'(nw) : 0);
        @(posedge clk); #1;
        cmd_n = 1'b1; strt_n = 1'b1; bus_addr = '0; wr = 1'b0; be_n = 4'hF;
        if (exp_hit && w)
            for (int b = 0; b < 4; b++)
                if (!ben[b]) model[idx][8*b +: 8] = d[8*b +: 8];
        @(posedge clk);
        @(negedge clk);
        chk(sz32_n && !wait_req && !rd_oe, "R10", "release",
            {29'd0, sz32_n, wait_req, rd_oe}, 32'h4);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(sz32_n == 1'b1, "R1", "sz32_n after reset", 32'(sz32_n), 1);
        chk(wait_req == 1'b0, "R1", "wait_req after reset", 32'(wait_req), 0);
        chk(rd_oe == 1'b0, "R1", "rd_oe after reset", 32'(rd_oe), 0);
        bus_cycle(1, MEM_BASE, 0, 4'h0, 0, 0, 0, 1, 0, "R1");
    endtask

    task automatic t_mem_rw;
        bus_cycle(1, MEM_BASE + 12, 1, 4'h0, 32'hA5A5_1234, 0, 0, 1, 0, "R2");
        bus_cycle(1, MEM_BASE + 12, 0, 4'h0, 0, 0, 1, 1, 0, "R2");
    endtask

    task automatic t_byte_mask;
        bus_cycle(1, MEM_BASE + 20, 1, 4'h0, 32'hFFFF_FFFF, 0, 0, 1, 0, "R7");
        bus_cycle(1, MEM_BASE + 20, 1, 4'b1010, 32'h1122_3344, 0, 2, 1, 0, "R7");
        bus_cycle(1, MEM_BASE + 20, 0, 4'h0, 0, 0, 0, 1, 0, "R7");
        bus_cycle(1, MEM_BASE + 20, 1, 4'b0101, 32'hCAFE_0BAD, 0, 0, 1, 0, "R7");
        bus_cycle(1, MEM_BASE + 20, 0, 4'h0, 0, 0, 0, 1, 0, "R7");
    endtask

    task automatic t_io;
        bus_cycle(0, IO_BASE + 28, 1, 4'h0, 32'h0BAD_F00D, 0, 1, 1, 0, "R3");
        bus_cycle(0, IO_BASE + 28, 1, 4'h0, 32'hDEAD_BEEF, 1, 1, 0, 0, "R3");
        bus_cycle(0, IO_BASE + 28, 0, 4'h0, 0, 0, 0, 1, 0, "R3");
    endtask

    task automatic t_mem_aen;
        bus_cycle(1, MEM_BASE + 36, 1, 4'h0, 32'h1357_9BDF, 1, 0, 1, 0, "R4");
        bus_cycle(1, MEM_BASE + 36, 0, 4'h0, 0, 1, 3, 1, 0, "R4");
    endtask

    task automatic t_miss;
        bus_cycle(1, MEM_BASE + 32'h40, 1, 4'h0, 32'h7777_7777, 0, 2, 0, 0, "R5");
        bus_cycle(0, MEM_BASE, 1, 4'h0, 32'h6666_6666, 0, 2, 0, 0, "R5");
        bus_cycle(1, IO_BASE, 1, 4'h0, 32'h5555_5555, 0, 2, 0, 0, "R5");
        bus_cycle(1, MEM_BASE, 0, 4'h0, 0, 0, 0, 1, 0, "R5");
        bus_cycle(0, IO_BASE, 0, 4'h0, 0, 0, 0, 1, 0, "R5");
    endtask

    task automatic t_latch;
        bus_cycle(1, MEM_BASE + 44, 1, 4'h0, 32'h2468_ACE0, 0, 2, 1, 1, "R9");
        bus_cycle(1, MEM_BASE + 44, 0, 4'h0, 0, 0, 0, 1, 0, "R9");
        bus_cycle(1, MEM_BASE + 56, 0, 4'h0, 0, 0, 0, 1, 0, "R9");
        bus_cycle(1, MEM_BASE + 56, 0, 4'hF, 0, 0, 5, 1, 1, "R9");
    endtask

    task automatic t_waits;
        for (int n = 0; n < 8; n++)
            bus_cycle(1, MEM_BASE + 12, 0, 4'h0, 0, 0, 3'(n), 1, 0, "R6");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_mem_rw();
        t_byte_mask();
        t_io();
        t_mem_aen();
        t_miss();
        t_latch();
        t_waits();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule